// File: doc/BRIEF.md
# Image resize coefficient calculator

This block computes the setup values a two-dimensional image scaler needs for a given source and destination frame. A start strobe captures four sizes: source height, destination height, source width and destination width. The block then evaluates the two axes one after the other, height first, on a single shared axis engine. For each axis it checks that the request lies inside the scaler's limits. It then picks a power-of-two pre-shrink factor by repeated halving. Last, it divides out a 14-bit fractional step with 13 fraction bits.

When both axes succeed, a one-cycle `done` pulse presents a 32-bit setup word. That word holds a 2-bit shrink code and a 14-bit step for each axis. If either axis is out of range, `done` comes with `err` set, the run stops at that axis, and the setup word keeps its previous contents. The block has no data stream of its own. It is driven by a plain start strobe and reports through plain status pins, so there is no back-pressure. A start that arrives while `busy` is high is dropped.

Top module: `scaler_setup_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `warn` are low and `word` is zero.
- R2: A source size above 4096 on either axis ends the run with `err` set.
- R3: A destination size above 1024 on either axis ends the run with `err` set.
- R4: A shrink steeper than 8:1 (eight times the destination size less than the source size) ends the run with `err` set. Exactly 8:1 is accepted.
- R5: A destination size of 0 or 1 ends the run with `err` set, and no division is attempted.
- R6: The shrink code counts the halvings of the working size. A halving is done while the working size is above 1024 or at least twice the destination size, with at most two halvings, so the code is 0, 1 or 2.
- R7: The step equals floor(8192 * (working size - 1) / (destination size - 1)).
- R8: A step of 16384 or more is output as 0x3FFF, and `warn` is set with `done` when this happens on either axis.
- R9: `word` carries height shrink code in bits 31:30, height step in 29:16, width shrink code in 15:14 and width step in 13:0. It changes only together with a successful `done`.
- R10: Height is evaluated first. An error on either axis ends the run with `err` high, `warn` low and `word` unchanged. `done` rises 3 cycles after the start edge for a height error, and 31 + Kh cycles after it for a width error, where Kh is the height shrink code.
- R11: On success `done` rises 56 + Kh + Kw cycles after the start edge, where Kw is the width shrink code. It is high for exactly one cycle, and `busy` is low from that cycle on.
- R12: A start strobe while `busy` is high is ignored and does not change the running result or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe; sizes are captured on the same edge when idle |
| src_h | input | 16 | Source height in lines |
| dst_h | input | 16 | Destination height in lines |
| src_w | input | 16 | Source width in pixels |
| dst_w | input | 16 | Destination width in pixels |
| busy | output | 1 | High from the cycle after an accepted start until `done` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Run ended on an out-of-range axis; valid with `done`, held until the next start |
| warn | output | 1 | A step saturated; valid with `done`, held until the next start |
| word | output | 32 | Packed setup word for both axes |

## Verification
Every result is due at a fixed cycle count after the edge that captures `start`. That count is 3 for a height rejection, 31 + Kh for a width rejection, and 56 + Kh + Kw for a full result. The Kh and Kw counts follow from the halving rule, so the expected latency of each vector can be worked out by hand. The bench counts rising edges from the start edge and samples on the falling edge after each one. It records the count at which `done` is first seen and compares it with the expected latency. It checks `word`, `err` and `warn` in that same cycle, and checks that `done` is low one cycle later. For the dropped-start case, a second strobe with illegal sizes is sent in the middle of a run, and the first run's result and latency must come out unchanged.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int RSZ_SIZE_W    = 16;   // width of every size input
  localparam int RSZ_COEF_W    = 14;   // step width
  localparam int RSZ_FRAC_BITS = 13;   // fraction bits of the step
  localparam int RSZ_MAX_SRC   = 4096; // largest accepted source size
  localparam int RSZ_MAX_DST   = 1024; // largest accepted destination size
  localparam int RSZ_MAX_HALF  = 2;    // cap on pre-shrink halvings
  localparam int RSZ_RATIO_SH  = 3;    // log2 of steepest shrink ratio

  typedef enum logic [1:0] {
    AX_IDLE,
    AX_CHECK,
    AX_SHRINK,
    AX_DIV
  } ax_state_t;

  typedef enum logic [2:0] {
    TOP_IDLE,
    TOP_VGO,
    TOP_VWAIT,
    TOP_HGO,
    TOP_HWAIT
  } top_state_t;
endpackage

// File: rtl/rsz_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module rsz_divider #(
  parameter int NW = 23,
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DW:0]   rem_r;
  logic [NW-1:0] q_r;
  logic [DW-1:0] den_r;
  logic [CW-1:0] cnt_r;
  logic          run_r;
  logic [DW:0]   trial;
  logic          fits;

  assign trial = {rem_r[DW-1:0], q_r[NW-1]};
  assign fits  = trial >= {1'b0, den_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r <= '0;
      q_r   <= '0;
      den_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_r <= '0;
        q_r   <= num;
        den_r <= den;
        cnt_r <= CW'(NW);
        run_r <= 1'b1;
      end else if (run_r) begin
        rem_r <= fits ? (trial - {1'b0, den_r}) : trial;
        q_r   <= {q_r[NW-2:0], fits};
        cnt_r <= cnt_r - CW'(1);
        if (cnt_r == CW'(1)) begin
          run_r <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = q_r;
endmodule

// File: rtl/rsz_axis.sv
// One-axis engine: range checks, pre-shrink selection, step division.
module rsz_axis
  import rsz_pkg::*;
#(
  parameter int SIZE_W    = RSZ_SIZE_W,
  parameter int COEF_W    = RSZ_COEF_W,
  parameter int FRAC_BITS = RSZ_FRAC_BITS,
  parameter int MAX_SRC   = RSZ_MAX_SRC,
  parameter int MAX_DST   = RSZ_MAX_DST,
  parameter int MAX_HALF  = RSZ_MAX_HALF,
  parameter int RATIO_SH  = RSZ_RATIO_SH,
  localparam int DSC_W    = $clog2(MAX_HALF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] src_sz,
  input  logic [SIZE_W-1:0] dst_sz,
  output logic              done,
  output logic              err,
  output logic              warn,
  output logic [DSC_W-1:0]  dsc,
  output logic [COEF_W-1:0] coef
);
  localparam int DW   = $clog2(MAX_DST);
  localparam int NW   = FRAC_BITS + DW;
  localparam int WIDE = SIZE_W + RATIO_SH + 1;

  ax_state_t         state_r;
  logic [SIZE_W-1:0] src_r, dst_r, work_r;
  logic [DSC_W-1:0]  dsc_r;

  logic [WIDE-1:0] src_x, dst_x, work_x;
  logic            bad_src, bad_dst, bad_ratio, bad_div, any_bad;
  logic            halve, div_go, div_done, sat;
  logic [NW-1:0]   div_num, div_quo;
  logic [DW-1:0]   div_den;

  assign src_x  = WIDE'(src_r);
  assign dst_x  = WIDE'(dst_r);
  assign work_x = WIDE'(work_r);

  assign bad_src   = src_x > WIDE'(MAX_SRC);
  assign bad_dst   = dst_x > WIDE'(MAX_DST);
  assign bad_ratio = (dst_x << RATIO_SH) < src_x;
  assign bad_div   = dst_x < WIDE'(2);
  assign any_bad   = bad_src | bad_dst | bad_ratio | bad_div;

  assign halve  = ((work_x > WIDE'(MAX_DST)) || (work_x >= (dst_x << 1)))
                  && (dsc_r < DSC_W'(MAX_HALF));
  assign div_go = (state_r == AX_SHRINK) && !halve;

  assign div_num = NW'(work_r - SIZE_W'(1)) << FRAC_BITS;
  assign div_den = DW'(dst_r - SIZE_W'(1));
  assign sat     = |div_quo[NW-1:COEF_W];

  rsz_divider #(.NW(NW), .DW(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_go),
    .num   (div_num),
    .den   (div_den),
    .done  (div_done),
    .quo   (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r <= AX_IDLE;
      src_r   <= '0;
      dst_r   <= '0;
      work_r  <= '0;
      dsc_r   <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      warn    <= 1'b0;
      coef    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_r)
        AX_IDLE: if (start) begin
          src_r   <= src_sz;
          dst_r   <= dst_sz;
          state_r <= AX_CHECK;
        end
        AX_CHECK: begin
          if (any_bad) begin
            done    <= 1'b1;
            err     <= 1'b1;
            warn    <= 1'b0;
            state_r <= AX_IDLE;
          end else begin
            work_r  <= src_r;
            dsc_r   <= '0;
            state_r <= AX_SHRINK;
          end
        end
        AX_SHRINK: begin
          if (halve) begin
            work_r <= work_r >> 1;
            dsc_r  <= dsc_r + DSC_W'(1);
          end else begin
            state_r <= AX_DIV;
          end
        end
        AX_DIV: if (div_done) begin
          done    <= 1'b1;
          err     <= 1'b0;
          warn    <= sat;
          coef    <= sat ? '1 : div_quo[COEF_W-1:0];
          state_r <= AX_IDLE;
        end
        default: state_r <= AX_IDLE;
      endcase
    end
  end

  assign dsc = dsc_r;
endmodule

// File: rtl/scaler_setup_calc.sv
// Runs the axis engine for height then width and packs both results.
module scaler_setup_calc
  import rsz_pkg::*;
#(
  parameter int SIZE_W    = RSZ_SIZE_W,
  parameter int COEF_W    = RSZ_COEF_W,
  parameter int FRAC_BITS = RSZ_FRAC_BITS,
  parameter int MAX_SRC   = RSZ_MAX_SRC,
  parameter int MAX_DST   = RSZ_MAX_DST,
  parameter int MAX_HALF  = RSZ_MAX_HALF,
  parameter int RATIO_SH  = RSZ_RATIO_SH,
  localparam int DSC_W    = $clog2(MAX_HALF + 1),
  localparam int HALF_W   = DSC_W + COEF_W,
  localparam int WORD_W   = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] src_h,
  input  logic [SIZE_W-1:0] dst_h,
  input  logic [SIZE_W-1:0] src_w,
  input  logic [SIZE_W-1:0] dst_w,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              warn,
  output logic [WORD_W-1:0] word
);
  top_state_t        state_r;
  logic [SIZE_W-1:0] sh_r, dh_r, sw_r, dw_r;
  logic [HALF_W-1:0] vres_r;
  logic              vwarn_r;

  logic              ax_start, ax_done, ax_err, ax_warn, on_height;
  logic [SIZE_W-1:0] ax_src, ax_dst;
  logic [DSC_W-1:0]  ax_dsc;
  logic [COEF_W-1:0] ax_coef;

  assign on_height = (state_r == TOP_VGO) || (state_r == TOP_VWAIT);
  assign ax_start  = (state_r == TOP_VGO) || (state_r == TOP_HGO);
  assign ax_src    = on_height ? sh_r : sw_r;
  assign ax_dst    = on_height ? dh_r : dw_r;

  rsz_axis #(
    .SIZE_W(SIZE_W), .COEF_W(COEF_W), .FRAC_BITS(FRAC_BITS),
    .MAX_SRC(MAX_SRC), .MAX_DST(MAX_DST), .MAX_HALF(MAX_HALF),
    .RATIO_SH(RATIO_SH)
  ) u_axis (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ax_start),
    .src_sz (ax_src),
    .dst_sz (ax_dst),
    .done   (ax_done),
    .err    (ax_err),
    .warn   (ax_warn),
    .dsc    (ax_dsc),
    .coef   (ax_coef)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r <= TOP_IDLE;
      sh_r    <= '0;
      dh_r    <= '0;
      sw_r    <= '0;
      dw_r    <= '0;
      vres_r  <= '0;
      vwarn_r <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      warn    <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_r)
        TOP_IDLE: if (start) begin
          sh_r    <= src_h;
          dh_r    <= dst_h;
          sw_r    <= src_w;
          dw_r    <= dst_w;
          err     <= 1'b0;
          warn    <= 1'b0;
          state_r <= TOP_VGO;
        end
        TOP_VGO: state_r <= TOP_VWAIT;
        TOP_VWAIT: if (ax_done) begin
          if (ax_err) begin
            done    <= 1'b1;
            err     <= 1'b1;
            state_r <= TOP_IDLE;
          end else begin
            vres_r  <= {ax_dsc, ax_coef};
            vwarn_r <= ax_warn;
            state_r <= TOP_HGO;
          end
        end
        TOP_HGO: state_r <= TOP_HWAIT;
        TOP_HWAIT: if (ax_done) begin
          done    <= 1'b1;
          state_r <= TOP_IDLE;
          if (ax_err) begin
            err <= 1'b1;
          end else begin
            word <= {vres_r, ax_dsc, ax_coef};
            warn <= vwarn_r | ax_warn;
          end
        end
        default: state_r <= TOP_IDLE;
      endcase
    end
  end

  assign busy = (state_r != TOP_IDLE);
endmodule

// File: rtl/scaler_setup_calc_chk.sv
module scaler_setup_calc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        warn,
  input logic [31:0] word
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_word_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(word) && !warn));

  assert_word_moves_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> (done && !err));

  assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (word[31:30] != 2'b11 && word[15:14] != 2'b11));

  assert_sat_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err && warn) |-> (word[29:16] == 14'h3FFF || word[13:0] == 14'h3FFF));

  assert_busy_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
endmodule

bind scaler_setup_calc scaler_setup_calc_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .err   (err),
  .warn  (warn),
  .word  (word)
);

// File: tb/scaler_setup_calc_bench.sv
`timescale 1ns/1ps
module scaler_setup_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] src_h = '0, dst_h = '0, src_w = '0, dst_w = '0;
  logic        busy, done, err, warn;
  logic [31:0] word;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  scaler_setup_calc u_scaler_setup_calc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_h(src_h), .dst_h(dst_h), .src_w(src_w), .dst_w(dst_w),
    .busy(busy), .done(done), .err(err), .warn(warn), .word(word)
  );

  typedef struct packed {
    logic [15:0] sh, dh, sw, dw;
    logic [31:0] exp_word;
    logic        exp_err;
    logic        exp_warn;
    logic [7:0]  exp_lat;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R7 R9: height 1:1, width halved once
    '{16'd480,  16'd480,  16'd640,  16'd320,  {2'd0,14'd8192,2'd1,14'd8192},  1'b0, 1'b0, 8'd57, 8'd9},
    // R2: source height above limit, word kept
    '{16'd4097, 16'd600,  16'd10,   16'd10,   {2'd0,14'd8192,2'd1,14'd8192},  1'b1, 1'b0, 8'd3,  8'd2},
    // R7: upscale with floor
    '{16'd720,  16'd1024, 16'd1000, 16'd700,  {2'd0,14'd5757,2'd0,14'd11707}, 1'b0, 1'b0, 8'd56, 8'd7},
    // R4: 9:1 shrink rejected
    '{16'd900,  16'd100,  16'd10,   16'd10,   {2'd0,14'd5757,2'd0,14'd11707}, 1'b1, 1'b0, 8'd3,  8'd4},
    // R6 R8: one halving on height, capped two on width with saturation
    '{16'd100,  16'd40,   16'd4096, 16'd512,  {2'd1,14'd10292,2'd2,14'd16383}, 1'b0, 1'b1, 8'd59, 8'd8},
    // R3 R10: width destination above limit, width error timing
    '{16'd480,  16'd480,  16'd640,  16'd1025, {2'd1,14'd10292,2'd2,14'd16383}, 1'b1, 1'b0, 8'd31, 8'd3},
    // R8: step exactly 16384 saturates
    '{16'd2,    16'd2,    16'd100,  16'd13,   {2'd0,14'd8192,2'd2,14'd16383},  1'b0, 1'b1, 8'd58, 8'd8},
    // R5: destination of one
    '{16'd1,    16'd1,    16'd5,    16'd5,    {2'd0,14'd8192,2'd2,14'd16383},  1'b1, 1'b0, 8'd3,  8'd5},
    // R6: largest source and destination, two halvings
    '{16'd4096, 16'd1024, 16'd2,    16'd2,    {2'd2,14'd8192,2'd0,14'd8192},   1'b0, 1'b0, 8'd58, 8'd6},
    // R4: exactly 8:1 on width accepted
    '{16'd480,  16'd480,  16'd800,  16'd100,  {2'd0,14'd8192,2'd2,14'd16383},  1'b0, 1'b1, 8'd58, 8'd4},
    // R5: zero sizes rejected
    '{16'd0,    16'd0,    16'd2,    16'd2,    {2'd0,14'd8192,2'd2,14'd16383},  1'b1, 1'b0, 8'd3,  8'd5},
    // R10: width error after one height halving
    '{16'd640,  16'd320,  16'd1,    16'd1,    {2'd0,14'd8192,2'd2,14'd16383},  1'b1, 1'b0, 8'd32, 8'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input bit inject);
    int lat;
    @(negedge clk);
    src_h = v.sh; dst_h = v.dh; src_w = v.sw; dst_w = v.dw; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 300) begin
      if (inject && lat == 5) begin
        start = 1'b1; src_h = 16'd9000; dst_h = 16'd0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    start = 1'b0;
    check($sformatf("R%0d/R11 latency", v.rq), 32'(lat), 32'(v.exp_lat));
    check($sformatf("R%0d word", v.rq), word, v.exp_word);
    check($sformatf("R%0d err", v.rq), 32'(err), 32'(v.exp_err));
    check($sformatf("R%0d warn", v.rq), 32'(warn), 32'(v.exp_warn));
    check("R11 busy low at done", 32'(busy), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R11 done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    check("R1 err", 32'(err), 32'd0);
    check("R1 warn", 32'(warn), 32'd0);
    check("R1 word", word, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R12: a strobe with illegal sizes during a run is dropped
    run_vec(VECS[0], 1'b1);
    // R12: the dropped strobe left no run behind
    repeat (5) @(negedge clk);
    check("R12 idle after dropped start", 32'(busy), 32'd0);

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule